// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by fetching descriptors from a two-level table in memory. A requester presents the virtual address together with the translation base register value on a valid/ready request channel. The walker fetches one first-level descriptor. Depending on that descriptor's type, it then fetches one second-level descriptor. It returns a single response. The response carries the physical address, the four-bit domain, the two-bit access permission that applies to the addressed part of the page, and the cacheable and bufferable attributes. Instead of a translation, the response may report a fault and the level at which the fault arose.

Memory is reached through a word read port. It has a request channel that carries an address and a response channel that carries the data, and both use valid/ready. Only one walk is in flight at a time. After a request is accepted, no other request is taken until the response has been handed over.

The controller has six named states. `S_IDLE` waits for a request and moves to `S_L1_REQ` on accept. `S_L1_REQ` offers the first-level read and moves to `S_L1_WAIT` when the memory takes it. `S_L1_WAIT` waits for the descriptor. A coarse or fine table pointer moves it to `S_L2_REQ`. A section or an invalid entry moves it straight to `S_RESP`. `S_L2_REQ` offers the second-level read and moves to `S_L2_WAIT` when the memory takes it. `S_L2_WAIT` moves to `S_RESP` when the data arrives. `S_RESP` holds the response until the requester takes it, then returns to `S_IDLE`.

Top module: `table_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: The first read goes to {ttb[31:14], va[31:20], 2'b00}. The low 14 bits of ttb are ignored.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after that single read. The response has rsp_fault = 1, rsp_fault_level = 1, and paddr, domain, ap, cacheable and bufferable all 0.
- R4: A first-level descriptor with type 10 (section) ends the walk after one read. paddr = {desc[31:20], va[19:0]}, domain = desc[8:5], ap = desc[11:10], cacheable = desc[3], bufferable = desc[2], and no fault.
- R5: A first-level type 01 (coarse) leads to a second read at {desc[31:10], va[19:12], 2'b00}. A first-level type 11 (fine) leads to a second read at {desc[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 00 gives rsp_fault = 1 and rsp_fault_level = 2. The domain comes from first-level bits [8:5]. paddr, ap, cacheable and bufferable are 0.
- R7: A second-level type 01 (64 KB page) reached through a coarse table gives paddr = {desc[31:16], va[15:0]}. ap is the two-bit field at desc bits [4+2k +: 2], where k = va[15:14]. cacheable = desc[3], bufferable = desc[2], and the domain comes from the first level.
- R8: A second-level type 10 (4 KB page) reached through a coarse table gives paddr = {desc[31:12], va[11:0]}. ap is the field at desc[4+2k +: 2], where k = va[11:10]. cacheable, bufferable and domain follow the same rules as in R7.
- R9: A second-level type 11 (1 KB page) reached through a fine table gives paddr = {desc[31:10], va[9:0]} and ap = desc[5:4]. cacheable, bufferable and domain follow the same rules as in R7.
- R10: Some type combinations are level-2 faults, reported with the R6 encoding: type 11 reached through a coarse table, and types 01 or 10 reached through a fine table.
- R11: Handshake behaviour. A memory request holds its valid and address until it is taken. A response holds its valid and contents until rsp_ready. req_ready stays 0 from the moment a request is accepted until the response handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Translation base register value |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_ready | output | 1 | Walker takes descriptor data |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 2 | Selected access permission |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_level | output | 2 | Fault level, 1 or 2, 0 when no fault |

## Verification
The first-level read is offered one cycle after the request is accepted. Each descriptor's data is consumed one cycle after its read is taken. When a second level is needed, its read is offered in the cycle after the first-level data arrives. The response appears one cycle after the last descriptor is consumed. Inputs are driven on the falling edge. The bench then checks each of these outputs at the next falling edge after the rising edge that should produce it, so every check lands in the exact cycle its result is due. A one-cycle memory stall and a one-cycle response backpressure are inserted in chosen walks, to confirm that each channel holds its contents across the wait.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int unsigned AW         = 32;
    localparam int unsigned DOM_W      = 4;
    localparam int unsigned AP_W       = 2;
    localparam int unsigned LVL_W      = 2;
    localparam int unsigned TTB_LSB    = 14;
    localparam int unsigned SECT_LSB   = 20;
    localparam int unsigned LARGE_LSB  = 16;
    localparam int unsigned SMALL_LSB  = 12;
    localparam int unsigned TINY_LSB   = 10;
    localparam int unsigned COARSE_LSB = 10;
    localparam int unsigned FINE_LSB   = 12;
    localparam int unsigned DOM_LSB    = 5;
    localparam int unsigned SUBPAGES   = 4;
    localparam int unsigned SUB_SEL_W  = $clog2(SUBPAGES);

    typedef enum logic [1:0] {
        L1_INVALID = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_INVALID = 2'b00,
        L2_LARGE   = 2'b01,
        L2_SMALL   = 2'b10,
        L2_TINY    = 2'b11
    } l2_kind_e;

    typedef struct packed {
        logic [AW-1:0]    paddr;
        logic [DOM_W-1:0] domain;
        logic [AP_W-1:0]  ap;
        logic             cacheable;
        logic             bufferable;
        logic             fault;
        logic [LVL_W-1:0] level;
    } walk_res_t;

    localparam walk_res_t RES_ZERO = '0;

endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
    import tw_pkg::*;
(
    input  logic [AW-1:TTB_LSB]    ttb_hi,
    input  logic [AW-1:TINY_LSB]   va_hi,
    input  logic [AW-1:COARSE_LSB] l2_base,
    input  logic                   l2_fine,
    input  logic                   second,
    output logic [AW-1:0]          rd_addr
);

    localparam int unsigned L1_IDX_W = AW - SECT_LSB;
    localparam int unsigned C_IDX_W  = SECT_LSB - SMALL_LSB;
    localparam int unsigned F_IDX_W  = SECT_LSB - TINY_LSB;

    logic [AW-1:0] l1_addr;
    logic [AW-1:0] coarse_addr;
    logic [AW-1:0] fine_addr;

    always_comb begin
        l1_addr     = {ttb_hi, va_hi[AW-1 -: L1_IDX_W], 2'b00};
        coarse_addr = {l2_base, va_hi[SECT_LSB-1 -: C_IDX_W], 2'b00};
        fine_addr   = {l2_base[AW-1:FINE_LSB], va_hi[SECT_LSB-1 -: F_IDX_W], 2'b00};
        if (!second)
            rd_addr = l1_addr;
        else if (l2_fine)
            rd_addr = fine_addr;
        else
            rd_addr = coarse_addr;
    end

endmodule

// File: rtl/tw_l1_decode.sv
module tw_l1_decode
    import tw_pkg::*;
(
    input  logic [AW-1:0]       desc,
    input  logic [SECT_LSB-1:0] va_lo,
    output l1_kind_e            kind,
    output logic                need_l2,
    output walk_res_t           res
);

    logic unused_l1_bits;
    assign unused_l1_bits = ^{desc[SECT_LSB-1:12], desc[9], desc[4]};

    always_comb begin
        kind    = l1_kind_e'(desc[1:0]);
        need_l2 = 1'b0;
        res     = RES_ZERO;
        unique case (kind)
            L1_INVALID: begin
                res.fault = 1'b1;
                res.level = 2'd1;
            end
            L1_SECTION: begin
                res.paddr      = {desc[AW-1:SECT_LSB], va_lo};
                res.domain     = desc[DOM_LSB +: DOM_W];
                res.ap         = desc[11:10];
                res.cacheable  = desc[3];
                res.bufferable = desc[2];
            end
            L1_COARSE, L1_FINE: begin
                need_l2 = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tw_l2_decode.sv
module tw_l2_decode
    import tw_pkg::*;
(
    input  logic [AW-1:0]        desc,
    input  logic [LARGE_LSB-1:0] va_lo,
    input  logic                 via_fine,
    input  logic [DOM_W-1:0]     l1_domain,
    output walk_res_t            res
);

    logic [AP_W*SUBPAGES-1:0] ap_fields;
    logic [SUB_SEL_W-1:0]     large_sel;
    logic [SUB_SEL_W-1:0]     small_sel;
    logic [AP_W-1:0]          ap_pick [SUBPAGES];
    l2_kind_e                 kind;
    logic                     bad;

    assign ap_fields = desc[4 +: AP_W*SUBPAGES];
    assign large_sel = va_lo[LARGE_LSB-1 -: SUB_SEL_W];
    assign small_sel = va_lo[SMALL_LSB-1 -: SUB_SEL_W];

    for (genvar g = 0; g < SUBPAGES; g++) begin : g_sub
        assign ap_pick[g] = ap_fields[g*AP_W +: AP_W];
    end

    always_comb begin
        kind = l2_kind_e'(desc[1:0]);
        res  = RES_ZERO;
        bad  = 1'b0;
        unique case (kind)
            L2_INVALID: bad = 1'b1;
            L2_LARGE: begin
                bad       = via_fine;
                res.paddr = {desc[AW-1:LARGE_LSB], va_lo};
                res.ap    = ap_pick[large_sel];
            end
            L2_SMALL: begin
                bad       = via_fine;
                res.paddr = {desc[AW-1:SMALL_LSB], va_lo[SMALL_LSB-1:0]};
                res.ap    = ap_pick[small_sel];
            end
            L2_TINY: begin
                bad       = !via_fine;
                res.paddr = {desc[AW-1:TINY_LSB], va_lo[TINY_LSB-1:0]};
                res.ap    = ap_pick[0];
            end
        endcase
        res.domain     = l1_domain;
        res.cacheable  = desc[3];
        res.bufferable = desc[2];
        if (bad) begin
            res        = RES_ZERO;
            res.domain = l1_domain;
            res.fault  = 1'b1;
            res.level  = 2'd2;
        end
    end

endmodule

// File: rtl/table_walker.sv
module table_walker
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_vaddr,
    input  logic [AW-1:0]    req_ttb,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [AW-1:0]    rsp_paddr,
    output logic [DOM_W-1:0] rsp_domain,
    output logic [AP_W-1:0]  rsp_ap,
    output logic             rsp_cacheable,
    output logic             rsp_bufferable,
    output logic             rsp_fault,
    output logic [LVL_W-1:0] rsp_fault_level
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } state_e;

    state_e state_q, state_d;

    logic [AW-1:0]          va_q;
    logic [AW-1:TTB_LSB]    ttb_q;
    logic [AW-1:COARSE_LSB] l2_base_q;
    logic                   l2_fine_q;
    logic [DOM_W-1:0]       l1_dom_q;
    walk_res_t              res_q;

    l1_kind_e  l1_kind;
    logic      l1_need_l2;
    walk_res_t l1_res;
    walk_res_t l2_res;

    logic req_fire, memreq_fire, memrsp_fire, rsp_fire;

    tw_addr_gen u_addr (
        .ttb_hi  (ttb_q),
        .va_hi   (va_q[AW-1:TINY_LSB]),
        .l2_base (l2_base_q),
        .l2_fine (l2_fine_q),
        .second  (state_q == S_L2_REQ),
        .rd_addr (mem_req_addr)
    );

    tw_l1_decode u_l1 (
        .desc    (mem_rsp_data),
        .va_lo   (va_q[SECT_LSB-1:0]),
        .kind    (l1_kind),
        .need_l2 (l1_need_l2),
        .res     (l1_res)
    );

    tw_l2_decode u_l2 (
        .desc      (mem_rsp_data),
        .va_lo     (va_q[LARGE_LSB-1:0]),
        .via_fine  (l2_fine_q),
        .l1_domain (l1_dom_q),
        .res       (l2_res)
    );

    assign req_fire    = req_valid && req_ready;
    assign memreq_fire = mem_req_valid && mem_req_ready;
    assign memrsp_fire = mem_rsp_valid && mem_rsp_ready;
    assign rsp_fire    = rsp_valid && rsp_ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_fire) state_d = S_L1_REQ;
            S_L1_REQ:  if (memreq_fire) state_d = S_L1_WAIT;
            S_L1_WAIT: if (memrsp_fire) state_d = l1_need_l2 ? S_L2_REQ : S_RESP;
            S_L2_REQ:  if (memreq_fire) state_d = S_L2_WAIT;
            S_L2_WAIT: if (memrsp_fire) state_d = S_RESP;
            S_RESP:    if (rsp_fire) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q      <= '0;
            ttb_q     <= '0;
            l2_base_q <= '0;
            l2_fine_q <= 1'b0;
            l1_dom_q  <= '0;
            res_q     <= RES_ZERO;
        end else begin
            if (req_fire) begin
                va_q  <= req_vaddr;
                ttb_q <= req_ttb[AW-1:TTB_LSB];
            end
            if (state_q == S_L1_WAIT && memrsp_fire) begin
                l2_base_q <= mem_rsp_data[AW-1:COARSE_LSB];
                l2_fine_q <= (l1_kind == L1_FINE);
                l1_dom_q  <= mem_rsp_data[DOM_LSB +: DOM_W];
                res_q     <= l1_res;
            end
            if (state_q == S_L2_WAIT && memrsp_fire)
                res_q <= l2_res;
        end
    end

    // outputs
    always_comb begin
        req_ready       = (state_q == S_IDLE);
        mem_req_valid   = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
        mem_rsp_ready   = (state_q == S_L1_WAIT) || (state_q == S_L2_WAIT);
        rsp_valid       = (state_q == S_RESP);
        rsp_paddr       = res_q.paddr;
        rsp_domain      = res_q.domain;
        rsp_ap          = res_q.ap;
        rsp_cacheable   = res_q.cacheable;
        rsp_bufferable  = res_q.bufferable;
        rsp_fault       = res_q.fault;
        rsp_fault_level = res_q.level;
    end

    p_memreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_ap) && $stable(rsp_fault) && $stable(rsp_domain));

    p_busy_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid || mem_rsp_ready) |-> !req_ready);

    p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_rsp_ready && !rsp_valid);

    p_rsp_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(mem_rsp_valid && mem_rsp_ready));

    p_fault_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault ? (rsp_fault_level == 2'd1 || rsp_fault_level == 2'd2)
                                 : (rsp_fault_level == 2'd0)));

    p_fault_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_ap == '0
            && !rsp_cacheable && !rsp_bufferable);

    p_l1_fault_dom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && rsp_fault_level == 2'd1 |-> rsp_domain == '0);

endmodule

// File: tb/table_walker_test.sv
`timescale 1ns/1ps
module table_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_ttb = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_domain;
    logic [1:0]  rsp_ap;
    logic        rsp_cacheable;
    logic        rsp_bufferable;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_level;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    table_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_ttb(req_ttb),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] field(input logic [31:0] d, input int k);
        return 2'((d >> (4 + 2 * k)) & 32'h3);
    endfunction

    task automatic walk(input int t1, input int t2, input int sub);
        logic [31:0] va, ttb, l1d, l2d, e_l1a, e_l2a, e_pa;
        logic [3:0]  e_dom;
        logic [1:0]  e_ap, e_lvl;
        logic        e_c, e_b, e_f, two, stall, bp;
        string       tag;
        va  = {12'(12'h812 + t1 * 16 + t2 * 4 + sub), 4'h7, 2'(sub), 2'h1, 2'(3 - sub), 10'h2B5};
        ttb = 32'hA1B0_0000 + 32'(t1 << 16) + 32'h1ABC;
        l1d = {12'(12'h3C1 + t2 * 7 + sub), 8'h5E, 2'(sub), 1'b1, 4'(t2 * 5 + sub), 1'b1,
               1'(sub), 1'(t2), 2'(t1)};
        l2d = {16'(16'hB00D + t2 * 3 + sub), 4'h6, 8'b00_01_11_10, 1'(~sub), 1'(sub >> 1), 2'(t2)};
        stall = (sub == 2);
        bp    = (sub != 1);
        two   = (t1 == 1 || t1 == 3);
        e_l1a = {ttb[31:14], va[31:20], 2'b00};
        e_l2a = (t1 == 3) ? {l1d[31:12], va[19:10], 2'b00} : {l1d[31:10], va[19:12], 2'b00};
        e_pa = '0; e_dom = '0; e_ap = '0; e_c = 0; e_b = 0; e_f = 0; e_lvl = 0;
        if (t1 == 0) begin
            tag = "R3"; e_f = 1; e_lvl = 2'd1;
        end else if (t1 == 2) begin
            tag = "R4"; e_pa = {l1d[31:20], va[19:0]}; e_dom = l1d[8:5];
            e_ap = l1d[11:10]; e_c = l1d[3]; e_b = l1d[2];
        end else begin
            e_dom = l1d[8:5];
            if (t2 == 0) begin
                tag = "R6"; e_f = 1; e_lvl = 2'd2;
            end else if ((t1 == 1 && t2 == 3) || (t1 == 3 && t2 != 3)) begin
                tag = "R10"; e_f = 1; e_lvl = 2'd2;
            end else begin
                e_c = l2d[3]; e_b = l2d[2];
                if (t2 == 1) begin
                    tag = "R7"; e_pa = {l2d[31:16], va[15:0]}; e_ap = field(l2d, int'(va[15:14]));
                end else if (t2 == 2) begin
                    tag = "R8"; e_pa = {l2d[31:12], va[11:0]}; e_ap = field(l2d, int'(va[11:10]));
                end else begin
                    tag = "R9"; e_pa = {l2d[31:10], va[9:0]}; e_ap = l2d[5:4];
                end
            end
        end

        // S_IDLE: request
        chk("R11 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1; req_vaddr = va; req_ttb = ttb; mem_req_ready = !stall;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_vaddr = ~va; req_ttb = ~ttb;
        chk("R2 l1 read addr", {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, e_l1a});
        chk("R11 busy not ready", 64'(req_ready), 64'd0);
        if (stall) begin
            @(posedge clk); @(negedge clk);
            chk("R11 stalled read held", {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, e_l1a});
            mem_req_ready = 1;
        end
        @(posedge clk); @(negedge clk);
        mem_req_ready = 0;
        chk("R11 read dropped after take", 64'(mem_req_valid), 64'd0);
        mem_rsp_valid = 1; mem_rsp_data = l1d;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
        if (two) begin
            chk("R5 l2 read addr", {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, e_l2a});
            mem_req_ready = 1;
            @(posedge clk); @(negedge clk);
            mem_req_ready = 0;
            mem_rsp_valid = 1; mem_rsp_data = l2d;
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
        end else begin
            chk({tag, " single read"}, 64'(mem_req_valid), 64'd0);
        end

        // S_RESP
        chk({tag, " response"},
            {20'd0, rsp_valid, rsp_fault, rsp_fault_level, rsp_paddr, rsp_domain, rsp_ap,
             rsp_cacheable, rsp_bufferable},
            {20'd0, 1'b1, e_f, e_lvl, e_pa, e_dom, e_ap, e_c, e_b});
        if (bp) begin
            @(posedge clk); @(negedge clk);
            chk("R11 response held",
                {rsp_valid, req_ready, rsp_paddr, rsp_ap, 28'd0}, {1'b1, 1'b0, e_pa, e_ap, 28'd0});
        end
        rsp_ready = 1;
        @(posedge clk); @(negedge clk);
        rsp_ready = 0;
        chk("R11 back to idle", {62'd0, rsp_valid, req_ready}, {62'd0, 1'b0, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset no read", 64'(mem_req_valid), 64'd0);
        chk("R1 reset no rsp", 64'(rsp_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        for (int t1 = 0; t1 < 4; t1++)
            for (int t2 = 0; t2 < 4; t2++)
                for (int sub = 0; sub < 4; sub++)
                    walk(t1, t2, sub);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule